// File: doc/BRIEF.md
# Dual-Host Register Write Arbiter

This block sits in front of a shared register file and merges the write traffic of two hosts. The general host is a serial front end that may address the whole 8-bit register space. The priority host uses a narrow 2-bit address space that reaches three registers only. It holds an active-low enable for as long as it owns those registers. While that enable is low, the general host is locked out of a small reserved address set: 0xF0 and 0xF1, which form a split register pair, plus 0xEC and 0xF2. The general host can still write every other address.

A general-host write that hits the reserved set while the priority host is active is discarded. For that write the block raises a one-cycle reject pulse. Nothing is queued. The general host must send the write again after the enable has returned high, and only that second write reaches the register file. When there is no conflict, both hosts can commit in the same cycle. The register file therefore receives one write port with two lanes: lane A carries general-host traffic and lane B carries priority-host traffic that has already been translated into the general address space.

All inputs are sampled on the rising clock edge, and the enable is expected to be synchronous to the clock. Every result appears on the registered outputs one cycle later.

Top module: `dual_host_wr_arb`

## Requirements
- R1: While rst_n is low, every output (both lane enables, addresses, data and gen_reject) is zero.
- R2: With pri_en_n high, a general write (gen_valid high) to any address appears on lane A one cycle later, with the same address and data, and gen_reject stays low.
- R3: With pri_en_n low, a general write to any address outside {0xF0, 0xF1, 0xEC, 0xF2} appears on lane A one cycle later, unchanged.
- R4: With pri_en_n low, a general write to 0xF0, 0xF1, 0xEC or 0xF2 is dropped: lane A stays idle in the next cycle and gen_reject is high for exactly that one cycle.
- R5: With pri_en_n low, a priority write (pri_valid high) appears on lane B one cycle later, carrying the priority data and a translated address: 0 becomes 0xF0, 1 becomes 0xEC and 2 becomes 0xF2.
- R6: A priority write is ignored, with lane B idle in the next cycle, when pri_en_n is high or when pri_addr is 3.
- R7: A general write and a priority write presented in the same cycle without a conflict are both committed in the next cycle, one on each lane.
- R8: A dropped write is never replayed. The same write sent again after pri_en_n returns high commits on lane A one cycle later.
- R9: gen_reject is high only in the cycle after a blocked general write, and it is never high following a cycle in which pri_en_n was high or gen_valid was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_valid | input | 1 | General host write strobe |
| gen_addr | input | AW (8) | General host address |
| gen_data | input | DW (8) | General host write data |
| pri_en_n | input | 1 | Priority host active, active low |
| pri_valid | input | 1 | Priority host write strobe |
| pri_addr | input | PAW (2) | Priority host address (0..2 valid) |
| pri_data | input | DW (8) | Priority host write data |
| wa_en | output | 1 | Lane A write enable (general host) |
| wa_addr | output | AW (8) | Lane A address |
| wa_data | output | DW (8) | Lane A data |
| wb_en | output | 1 | Lane B write enable (priority host) |
| wb_addr | output | AW (8) | Lane B address, translated |
| wb_data | output | DW (8) | Lane B data |
| gen_reject | output | 1 | One-cycle pulse for a dropped general write |

## Verification
Every result of this block, whether a lane-A commit, a lane-B commit or a reject pulse, is due exactly one rising edge after the inputs that cause it. An enable change takes effect for a write sampled on the same edge. The bench applies inputs just after a falling edge. Its behavioural model computes the expected lane and reject values from those inputs, and it compares them at the next falling edge, which is half a period after the register stage has updated. Because the comparison happens in every cycle, a missing pulse, a pulse that lasts too long or a stale replay of a dropped write shows up in the exact cycle where it occurs.

// File: rtl/dual_host_wr_arb.sv
module dual_host_wr_arb #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PAW = 2,
  parameter logic [AW-1:0] PAIR_HI = 8'hF0,
  parameter logic [AW-1:0] PAIR_LO = 8'hF1,
  parameter logic [AW-1:0] SLOT1 = 8'hEC,
  parameter logic [AW-1:0] SLOT2 = 8'hF2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gen_valid,
  input  logic [AW-1:0]  gen_addr,
  input  logic [DW-1:0]  gen_data,
  input  logic           pri_en_n,
  input  logic           pri_valid,
  input  logic [PAW-1:0] pri_addr,
  input  logic [DW-1:0]  pri_data,
  output logic           wa_en,
  output logic [AW-1:0]  wa_addr,
  output logic [DW-1:0]  wa_data,
  output logic           wb_en,
  output logic [AW-1:0]  wb_addr,
  output logic [DW-1:0]  wb_data,
  output logic           gen_reject
);

  logic in_reserved, gen_blocked, pri_ok;
  logic [AW-1:0] pri_map;

  assign in_reserved = (gen_addr == PAIR_HI) || (gen_addr == PAIR_LO) ||
                       (gen_addr == SLOT1)   || (gen_addr == SLOT2);
  assign gen_blocked = gen_valid && !pri_en_n && in_reserved;
  assign pri_ok      = pri_valid && !pri_en_n && (pri_addr < PAW'(3));

  always_comb begin
    case (pri_addr)
      PAW'(0):  pri_map = PAIR_HI;
      PAW'(1):  pri_map = SLOT1;
      default:  pri_map = SLOT2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wa_en      <= 1'b0;
      wa_addr    <= '0;
      wa_data    <= '0;
      wb_en      <= 1'b0;
      wb_addr    <= '0;
      wb_data    <= '0;
      gen_reject <= 1'b0;
    end else begin
      wa_en      <= gen_valid && !gen_blocked;
      wa_addr    <= gen_addr;
      wa_data    <= gen_data;
      wb_en      <= pri_ok;
      wb_addr    <= pri_map;
      wb_data    <= pri_data;
      gen_reject <= gen_blocked;
    end
  end

  // R2
  free_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_valid && pri_en_n |=> wa_en && !gen_reject &&
      wa_addr == $past(gen_addr) && wa_data == $past(gen_data));

  // R4
  block_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_valid && !pri_en_n && (gen_addr == 8'hF0 || gen_addr == 8'hF1 ||
      gen_addr == 8'hEC || gen_addr == 8'hF2) |=> !wa_en && gen_reject);

  // R5
  pri_map0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_valid && !pri_en_n && pri_addr == PAW'(0) |=> wb_en && wb_addr == PAIR_HI);

  // R6
  pri_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_en_n |=> !wb_en);

  // R7
  lanes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wa_en && wb_en |-> wa_addr != wb_addr);

  // R9
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_reject |-> $past(gen_valid) && !$past(pri_en_n));

  // R4
  reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_reject |-> !wa_en);

endmodule

// File: tb/test_dual_host_wr_arb.sv
module test_dual_host_wr_arb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic gen_valid = 0, pri_en_n = 1, pri_valid = 0;
  logic [7:0] gen_addr = 0, gen_data = 0, pri_data = 0;
  logic [1:0] pri_addr = 0;
  logic wa_en, wb_en, gen_reject;
  logic [7:0] wa_addr, wa_data, wb_addr, wb_data;

  int total = 0, bad = 0;
  bit finished = 0;

  bit e_wa, e_wb, e_rej;
  logic [7:0] e_wa_a, e_wa_d, e_wb_a, e_wb_d;
  bit e_en_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_host_wr_arb i_dual_host_wr_arb (
    .clk(clk), .rst_n(rst_n),
    .gen_valid(gen_valid), .gen_addr(gen_addr), .gen_data(gen_data),
    .pri_en_n(pri_en_n), .pri_valid(pri_valid), .pri_addr(pri_addr), .pri_data(pri_data),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .gen_reject(gen_reject));

  function automatic bit is_res(logic [7:0] a);
    logic [7:0] q[$] = '{8'hF0, 8'hF1, 8'hEC, 8'hF2};
    foreach (q[i]) if (q[i] == a) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] pmap(logic [1:0] a);
    logic [7:0] q[$] = '{8'hF0, 8'hEC, 8'hF2};
    return q[a];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit gv, logic [7:0] ga, logic [7:0] gd, bit en_n,
                     bit pv, logic [1:0] pa, logic [7:0] pd, string tag);
    string ra, rb, rr;
    gen_valid = gv; gen_addr = ga; gen_data = gd;
    pri_en_n = en_n; pri_valid = pv; pri_addr = pa; pri_data = pd;
    e_rej  = gv && !en_n && is_res(ga);
    e_wa   = gv && !e_rej;
    e_wa_a = ga; e_wa_d = gd;
    e_wb   = pv && !en_n && pa != 2'd3;
    e_wb_a = e_wb ? pmap(pa) : 8'h00; e_wb_d = pd;
    @(negedge clk);
    ra = (tag != "") ? tag : (e_rej ? "R4" : (en_n ? "R2" : "R3"));
    rb = (tag != "") ? tag : (e_wb ? "R5" : "R6");
    rr = (tag != "") ? tag : (e_rej ? "R4" : "R9");
    check(wa_en == e_wa, ra, "wa_en", wa_en, e_wa);
    if (e_wa) begin
      check(wa_addr == e_wa_a, ra, "wa_addr", wa_addr, e_wa_a);
      check(wa_data == e_wa_d, ra, "wa_data", wa_data, e_wa_d);
    end
    check(wb_en == e_wb, rb, "wb_en", wb_en, e_wb);
    if (e_wb) begin
      check(wb_addr == e_wb_a, rb, "wb_addr", wb_addr, e_wb_a);
      check(wb_data == e_wb_d, rb, "wb_data", wb_data, e_wb_d);
    end
    check(gen_reject == e_rej, rr, "gen_reject", gen_reject, e_rej);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({wa_en, wb_en, gen_reject} == 0, "R1", "enables", {wa_en, wb_en, gen_reject}, 0);
    check({wa_addr, wa_data, wb_addr, wb_data} == 0, "R1", "buses",
          {wa_addr, wa_data, wb_addr, wb_data}, 0);
    rst_n = 1;
    // R2: free access
    cyc(1, 8'hF0, 8'h11, 1, 0, 0, 0, "");
    cyc(1, 8'h05, 8'h22, 1, 0, 0, 0, "");
    // R6: priority ignored while inactive
    cyc(0, 0, 0, 1, 1, 0, 8'h33, "");
    // R3, R4, R5
    cyc(1, 8'h40, 8'h44, 0, 0, 0, 0, "");
    cyc(1, 8'hF1, 8'h55, 0, 0, 0, 0, "");
    cyc(1, 8'hEC, 8'h56, 0, 1, 1, 8'h66, "");
    cyc(0, 0, 0, 0, 1, 2, 8'h77, "");
    cyc(0, 0, 0, 0, 1, 3, 8'h78, "");   // R6 invalid address
    // R7: both lanes in one cycle
    cyc(1, 8'h10, 8'h88, 0, 1, 0, 8'h99, "R7");
    // R8: dropped write, idle, then reissued after release
    cyc(1, 8'hF2, 8'hAB, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, 0, 0, 0, "R8");
    cyc(1, 8'hF2, 8'hAB, 1, 0, 0, 0, "R8");
    // R9: reject lasts one cycle
    cyc(1, 8'hF0, 8'h01, 0, 0, 0, 0, "");
    cyc(0, 8'hF0, 8'h01, 0, 0, 0, 0, "");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = ($urandom % 3 == 0) ? pmap(2'($urandom % 3)) : 8'($urandom);
      if ($urandom % 5 == 0) a = 8'hF1;
      cyc(1'($urandom), a, 8'($urandom), ($urandom % 4) != 0 ? 1'b0 : 1'b1,
          1'($urandom), 2'($urandom), 8'($urandom), "");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule